// File: doc/BRIEF.md
# Converter Output Code Formatter

This block sits between a 10-bit conversion pipeline and the chip's output pins. It takes one raw sample on every rising edge of the conversion clock and puts out one formatted word per clock. The word can be plain binary, Gray code, or a differential form. In the differential forms each word is the current sample minus the sample from two clocks before. The differential forms can also be Gray coded. With the differential forms the receiver needs an anchor, so two absolute samples are sent on consecutive clocks at a selectable distance after each optical-black pulse.

A pre-blank input replaces the word with a clamp code. Its effect is delayed by a fixed number of clocks so that it lines up with the pipeline behind the converter. Two inversion controls flip the top bit and the lower bits independently. A standby input releases the bus to high impedance and drops the output-enable flag.

Top module: `conv_code_fmt`

## Requirements
- R1: With `enc_sel_i` = 00 (binary), the sample presented before rising edge n appears unchanged on `data_o` after edge n+1.
- R2: With `enc_sel_i` = 01 (Gray), the word is v XOR (v >> 1), where v is the sample presented before edge n. It appears after edge n+1.
- R3: With `enc_sel_i` = 10 (differential binary), the word for the sample at edge n is (x[n] − x[n−2]) mod 1024. Samples before the first edge after reset count as 0.
- R4: With `enc_sel_i` = 11 (differential Gray), the difference of R3 is formed first and then Gray coded as in R2.
- R5: Let a be the first rising edge that samples `obp_i` high after it was low, with `obp_fall_i` = 0, and let P = 3 + `ref_pos_i`. In the differential modes, the samples taken at edges a+P and a+P+1 are sent as absolute values: the raw sample in mode 10, its Gray code in mode 11. A new OBP rising restarts the count.
- R6: With `obp_fall_i` = 1, OBP is captured on the falling clock edge. When OBP rises between a rising edge and the following falling edge, the reference window opens one clock earlier than with rising-edge capture.
- R7: `pblk_i` high at rising edge n forces the word after edge n+10 to the clamp code 2·`clamp_i` + 14. The clamp code bypasses encoding; only the inversions of R8 still apply to it.
- R8: `inv_msb_i` inverts bit 9 of the output word. `inv_rest_i` inverts bits 8..0. Both together invert all 10 bits.
- R9: While `standby_i` is high, `oe_o` is low and `data_o` is high impedance, with no clock delay.
- R10: After reset with standby low, `data_o` is 0 and `oe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 10 | Raw conversion result |
| obp_i | input | 1 | Optical-black pulse |
| pblk_i | input | 1 | Pre-blank request |
| clamp_i | input | 5 | Clamp setting; code = 2·value + 14 |
| enc_sel_i | input | 2 | Encoding select |
| ref_pos_i | input | 2 | Reference window position after OBP |
| obp_fall_i | input | 1 | Capture OBP on the falling edge |
| inv_msb_i | input | 1 | Invert bit 9 |
| inv_rest_i | input | 1 | Invert bits 8..0 |
| standby_i | input | 1 | Release the bus |
| data_o | output | 10 | Formatted output word |
| oe_o | output | 1 | High when the bus is driven |

## Verification
The assertions assume the following about the inputs:
- OBP is a clean level that stays high or low for at least one full clock.
- The capture-edge select changes only while OBP has been low for some cycles.
- Reset is held for several clocks, so the two-clock history assertion compares values from reset.

The stimulus keeps to these assumptions in the following ways:
- All inputs are driven a quarter period after the rising edge.
- OBP pulses are several clocks wide and placed away from every change of the edge select.
- Samples that hit 0 and 1023 are mixed in, so the modular wrap of the difference occurs.

// File: rtl/cof_pkg.sv
package cof_pkg;
  typedef enum logic [1:0] {
    ENC_BIN   = 2'b00,
    ENC_GRAY  = 2'b01,
    ENC_DBIN  = 2'b10,
    ENC_DGRAY = 2'b11
  } enc_e;

  localparam int unsigned REF_BASE   = 3;
  localparam int unsigned CLAMP_BASE = 14;
  localparam int unsigned DIFF_DIST  = 2;
endpackage

// File: rtl/obp_window.sv
module obp_window
  import cof_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned POS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             obp_i,
  input  logic             fall_sel_i,
  input  logic [POS_W-1:0] ref_pos_i,
  output logic             ref_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic obp_pos_q, obp_neg_q, obp_d_q, obp_s, start;
  logic [CNT_W-1:0] cnt_q, cnt_d, pos_w;
  logic ref_q, ref_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) obp_pos_q <= 1'b0;
    else         obp_pos_q <= obp_i;

  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) obp_neg_q <= 1'b0;
    else         obp_neg_q <= obp_i;

  assign obp_s = fall_sel_i ? obp_neg_q : obp_pos_q;
  assign start = obp_s & ~obp_d_q;
  assign pos_w = CNT_W'(REF_BASE) + CNT_W'(ref_pos_i);

  always_comb begin
    if (start)                             cnt_d = CNT_W'(1);
    else if (cnt_q != '0 && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    else                                   cnt_d = cnt_q;
  end

  assign ref_d = (cnt_d == pos_w) || (cnt_d == pos_w + CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      obp_d_q <= 1'b0;
      cnt_q   <= '0;
      ref_q   <= 1'b0;
    end else begin
      obp_d_q <= obp_s;
      cnt_q   <= cnt_d;
      ref_q   <= ref_d;
    end

  assign ref_o = ref_q;

  assert_obp_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == CNT_W'(1)));

  assert_ref_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> (cnt_q >= CNT_W'(REF_BASE)) && (cnt_q <= CNT_W'(REF_BASE + 4)));
endmodule

// File: rtl/pblk_delay.sv
module pblk_delay #(
  parameter int unsigned DEPTH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [DEPTH-1:0] line_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) line_q <= '0;
        else         line_q <= in_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) line_q <= '0;
        else         line_q <= {line_q[DEPTH-2:0], in_i};
    end
  endgenerate

  assign out_o = line_q[DEPTH-1];
endmodule

// File: rtl/code_encoder.sv
module code_encoder
  import cof_pkg::*;
#(
  parameter int unsigned W       = 10,
  parameter int unsigned CLAMP_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [W-1:0]       sample_i,
  input  logic               ref_i,
  input  logic               blank_i,
  input  logic [CLAMP_W-1:0] clamp_i,
  input  enc_e               enc_i,
  input  logic               inv_msb_i,
  input  logic               inv_rest_i,
  output logic [W-1:0]       out_o
);
  logic [W-1:0] hist_q [DIFF_DIST+1];
  logic [W-1:0] diff, pick, coded, clamp_code, base, inv_mask, out_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i <= DIFF_DIST; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= sample_i;
      for (int i = 1; i <= DIFF_DIST; i++) hist_q[i] <= hist_q[i-1];
    end

  // wrap to W bits: carry out is dropped
  assign diff       = hist_q[0] - hist_q[DIFF_DIST];
  assign pick       = (enc_i[1] && !ref_i) ? diff : hist_q[0];
  assign coded      = enc_i[0] ? (pick ^ (pick >> 1)) : pick;
  assign clamp_code = (W'(clamp_i) << 1) + W'(CLAMP_BASE);
  assign base       = blank_i ? clamp_code : coded;
  assign inv_mask   = {inv_msb_i, {(W-1){inv_rest_i}}};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) out_q <= '0;
    else         out_q <= base ^ inv_mask;

  assign out_o = out_q;

  assert_hist_dist_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_q[DIFF_DIST] == $past(hist_q[0], 2));

  assert_bin_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_i == ENC_BIN && !inv_msb_i && !inv_rest_i && !blank_i)
      |=> out_q == $past(hist_q[0]));
endmodule

// File: rtl/conv_code_fmt.sv
module conv_code_fmt
  import cof_pkg::*;
#(
  parameter int unsigned W         = 10,
  parameter int unsigned CLAMP_W   = 5,
  parameter int unsigned POS_W     = 2,
  parameter int unsigned PBLK_LAT  = 10,
  parameter int unsigned CNT_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [W-1:0]       sample_i,
  input  logic               obp_i,
  input  logic               pblk_i,
  input  logic [CLAMP_W-1:0] clamp_i,
  input  logic [1:0]         enc_sel_i,
  input  logic [POS_W-1:0]   ref_pos_i,
  input  logic               obp_fall_i,
  input  logic               inv_msb_i,
  input  logic               inv_rest_i,
  input  logic               standby_i,
  output logic [W-1:0]       data_o,
  output logic               oe_o
);
  logic ref_w, blank_w;
  logic [W-1:0] word_w;

  obp_window #(.CNT_W(CNT_W), .POS_W(POS_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .obp_i      (obp_i),
    .fall_sel_i (obp_fall_i),
    .ref_pos_i  (ref_pos_i),
    .ref_o      (ref_w)
  );

  pblk_delay #(.DEPTH(PBLK_LAT)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (pblk_i),
    .out_o  (blank_w)
  );

  code_encoder #(.W(W), .CLAMP_W(CLAMP_W)) u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .ref_i      (ref_w),
    .blank_i    (blank_w),
    .clamp_i    (clamp_i),
    .enc_i      (enc_e'(enc_sel_i)),
    .inv_msb_i  (inv_msb_i),
    .inv_rest_i (inv_rest_i),
    .out_o      (word_w)
  );

  assign oe_o   = ~standby_i;
  assign data_o = oe_o ? word_w : {W{1'bz}};
endmodule

// File: tb/conv_code_fmt_test.sv
module conv_code_fmt_test;
  localparam int N = 2048;
  localparam int L = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni;
  logic [9:0] sample;
  logic       obp, pblk, fall, invm, invr, stby;
  logic [4:0] clamp;
  logic [1:0] enc, rpos;
  logic [9:0] data;
  logic       oe;

  conv_code_fmt uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample), .obp_i(obp), .pblk_i(pblk),
    .clamp_i(clamp), .enc_sel_i(enc), .ref_pos_i(rpos), .obp_fall_i(fall),
    .inv_msb_i(invm), .inv_rest_i(invr), .standby_i(stby), .data_o(data), .oe_o(oe)
  );

  int xs[N], rps[N], encs[N], clps[N];
  bit obs[N], pbs[N], sts[N], fls[N], ims[N], irs[N];
  int e = 0, tests = 0, fails = 0;
  bit done = 0;

  function automatic int gx(int i);  return (i < 1 || i >= N) ? 0 : xs[i]; endfunction
  function automatic bit gob(int i); return (i < 1 || i >= N) ? 1'b0 : obs[i]; endfunction
  function automatic bit gpb(int i); return (i < 1 || i >= N) ? 1'b0 : pbs[i]; endfunction

  // most recent start edge s has count 1 at s; window is counts P and P+1
  function automatic bit is_ref(int k);
    int p = 3 + rps[k];
    for (int s = k; s >= 1 && s > k - 16; s--) begin
      bit st = fls[k] ? (gob(s) && !gob(s-1)) : (gob(s-1) && !gob(s-2));
      if (st) return (k - s == p - 1) || (k - s == p);
    end
    return 1'b0;
  endfunction

  function automatic int expect_word(int m);
    int v;
    if (gpb(m - L)) v = 2 * clps[m] + 14;
    else begin
      bit r = is_ref(m - 1);
      v = (encs[m] >= 2 && !r) ? ((gx(m-1) - gx(m-3)) & 1023) : gx(m-1);
      if (encs[m] % 2 == 1) v = v ^ (v >> 1);
    end
    if (ims[m]) v = v ^ 512;
    if (irs[m]) v = v ^ 511;
    return v;
  endfunction

  function automatic string label(int m);
    if (sts[m]) return "R9";
    if (gpb(m - L)) return "R7";
    if (encs[m] >= 2 && is_ref(m - 1)) return fls[m] ? "R6" : "R5";
    if (ims[m] || irs[m]) return "R8";
    case (encs[m])
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(int m);
    string lb = label(m);
    tests++;
    if (sts[m]) begin
      if (oe !== 1'b0) begin
        fails++;
        $display("FAIL %s edge %0d: oe=%0b expected 0", lb, m, oe);
      end
    end else begin
      int ex = expect_word(m);
      if (oe !== 1'b1 || data !== ex[9:0]) begin
        fails++;
        $display("FAIL %s edge %0d: data=%0d oe=%0b expected data=%0d oe=1", lb, m, data, oe, ex);
      end
    end
  endtask

  task automatic step(input logic [9:0] s, input bit o, input bit p, input bit sb);
    sample = s; obp = o; pblk = p; stby = sb;
    xs[e+1] = s; obs[e+1] = o; pbs[e+1] = p; sts[e+1] = sb;
    rps[e+1] = rpos; encs[e+1] = enc; clps[e+1] = clamp;
    fls[e+1] = fall; ims[e+1] = invm; irs[e+1] = invr;
    @(posedge clk);
    e++;
    #5;
    check(e);
  endtask

  function automatic logic [9:0] pat(int i);
    if (i % 7 == 0)  return 10'd1023;
    if (i % 11 == 0) return 10'd0;
    return 10'($urandom % 1024);
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 0; sample = 0; obp = 0; pblk = 0; fall = 0; invm = 0; invr = 0;
    stby = 0; clamp = 0; enc = 0; rpos = 0;
    repeat (3) @(posedge clk);
    #5 rst_ni = 1;
    tests++;
    if (data !== 10'd0 || oe !== 1'b1) begin
      fails++;
      $display("FAIL R10 reset: data=%0d oe=%0b expected data=0 oe=1", data, oe);
    end

    // R1..R5: each encoding, OBP pulses at all four window positions
    for (int m = 0; m < 4; m++) begin
      enc = 2'(m);
      for (int i = 0; i < 100; i++) begin
        rpos = 2'((i / 25) % 4);
        step(pat(i), (i % 25) >= 5 && (i % 25) <= 7, 1'b0, 1'b0);
      end
    end

    // R6: falling-edge OBP capture in both differential modes
    fall = 1;
    for (int m = 2; m < 4; m++) begin
      enc = 2'(m);
      for (int i = 0; i < 100; i++) begin
        rpos = 2'((i / 25) % 4);
        step(pat(i), (i % 25) >= 5 && (i % 25) <= 7, 1'b0, 1'b0);
      end
    end
    fall = 0;
    repeat (4) step(10'd0, 1'b0, 1'b0, 1'b0);

    // R7: pre-blank forcing with several clamp settings
    enc = 2'd1;
    for (int i = 0; i < 75; i++) begin
      clamp = (i < 25) ? 5'd0 : (i < 50) ? 5'd9 : 5'd31;
      step(pat(i), 1'b0, ((i % 25) >= 3 && (i % 25) <= 8) || i == 60, 1'b0);
    end

    // R8: inversion combinations, including a differential mode
    for (int k = 1; k < 4; k++) begin
      invm = k[1]; invr = k[0]; enc = 2'd0;
      for (int i = 0; i < 30; i++) step(pat(i), 1'b0, 1'b0, 1'b0);
    end
    enc = 2'd3;
    for (int i = 0; i < 30; i++) step(pat(i), i == 4, i == 15, 1'b0);
    invm = 0; invr = 0; enc = 2'd0;

    // R9: standby toggling
    for (int i = 0; i < 40; i++) step(pat(i), 1'b0, 1'b0, ((i / 5) % 2) == 1);

    done = 1;
    summary();
    $finish;
  end
endmodule